// File: doc/BRIEF.md
# Flash Sector Protection Guard

This block guards the program and erase path of a 4-Mbit (512 KB) serial flash array. It holds one protect bit for each of eleven protection sectors of mixed size. It applies commands that protect or unprotect a single sector or the whole array. It then judges every program or erase request against those bits. A request that touches any protected sector is refused as a whole. A refusal sets an error flag, and the flag stays set until the next request is judged.

A write-protect input freezes the protect bits while it is high, so software commands cannot change the protection state. A program request is confined to the 256-byte page that holds its start address, because the array wraps within the page. For this reason only that page's sector decides the result, whatever the byte count. An erase request names a block size. The block is aligned down to that size and may overlap several sectors.

Top module: `sect_guard`

## Requirements
- R1: After reset every protect bit reads 1 on `prot_bits`, and `grant`, `reject` and `err_flag` read 0.
- R2: A command with `pcmd_op`=0 sets, and `pcmd_op`=1 clears, only the bit of the sector that holds `pcmd_addr`. The change shows on `prot_bits` one cycle later. Bit i of `prot_bits` maps to these sectors: bits 0..6 are the 64 KB sectors at 0x00000..0x6FFFF, bit 7 is 0x70000..0x77FFF, bit 8 is 0x78000..0x79FFF, bit 9 is 0x7A000..0x7BFFF, and bit 10 is 0x7C000..0x7FFFF.
- R3: `pcmd_op`=2 sets all eleven bits, and `pcmd_op`=3 clears all eleven bits, one cycle later.
- R4: While `wp_lock` is 1, protect commands leave `prot_bits` unchanged.
- R5: A program request (`req_kind`=0) is granted only if the sector holding `req_addr` is unprotected. Addresses elsewhere in the same page never change the result.
- R6: Erase kinds 1, 2 and 3 (4 KB, 32 KB and 64 KB) align `req_addr` down to the block size. The request is refused if any sector overlapping that block is protected.
- R7: A full-array erase (`req_kind`=4) is refused if any protect bit is set, and granted otherwise.
- R8: Each request yields exactly one one-cycle pulse, on `grant` or on `reject`, in the cycle after it. No pulse appears without a request.
- R9: `err_flag` is loaded with the refusal result of each request and holds that value between requests.
- R10: A request in the same cycle as a protect command is judged against the protect bits as they stood before that command.
- R11: A request with `req_kind` 5, 6 or 7 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_lock | input | 1 | Write-protect; 1 freezes the protect bits |
| pcmd_valid | input | 1 | Protect command strobe |
| pcmd_op | input | 2 | 0 set one, 1 clear one, 2 set all, 3 clear all |
| pcmd_addr | input | 19 | Any address inside the target sector |
| req_valid | input | 1 | Program/erase request strobe |
| req_kind | input | 3 | 0 program, 1 erase 4 KB, 2 erase 32 KB, 3 erase 64 KB, 4 erase all |
| req_addr | input | 19 | Start address of the request |
| grant | output | 1 | One-cycle pulse: request allowed |
| reject | output | 1 | One-cycle pulse: request refused |
| err_flag | output | 1 | Refusal result of the latest request |
| prot_bits | output | 11 | Current protect bits, one per sector |

## Verification
A request and a protect command can land on the same clock edge. This matters most when the command changes the very sector the request touches. The bench drives this case in both directions: it protects sector 0 while a program to sector 0 is issued, and it clears all bits while a full-array erase is issued. The outcome is judged by the reference model, which decides each request from its own protect state before it applies that cycle's command. The following request then confirms that the command did take effect.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;
    localparam int ADDR_W = 19;
    localparam int NSEC   = 11;
    localparam int N_BIG  = 7;

    typedef enum logic [1:0] {
        PC_SET_ONE = 2'd0,
        PC_CLR_ONE = 2'd1,
        PC_SET_ALL = 2'd2,
        PC_CLR_ALL = 2'd3
    } pcmd_e;

    typedef enum logic [2:0] {
        RK_PROG = 3'd0,
        RK_E4K  = 3'd1,
        RK_E32K = 3'd2,
        RK_E64K = 3'd3,
        RK_CHIP = 3'd4
    } rkind_e;

    // First byte of sector i: seven 64 KB sectors, then 32 KB, 8 KB, 8 KB, 16 KB.
    function automatic logic [ADDR_W-1:0] sec_base(input int i);
        case (i)
            N_BIG:     return ADDR_W'(32'h70000);
            N_BIG + 1: return ADDR_W'(32'h78000);
            N_BIG + 2: return ADDR_W'(32'h7A000);
            N_BIG + 3: return ADDR_W'(32'h7C000);
            default:   return ADDR_W'(i << 16);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] sec_last(input int i);
        if (i == NSEC - 1) return '1;
        return sec_base(i + 1) - ADDR_W'(1);
    endfunction

    function automatic logic [ADDR_W-1:0] blk_lo(input logic [ADDR_W-1:0] a, input int w);
        return a & ~((ADDR_W'(1) << w) - ADDR_W'(1));
    endfunction

    function automatic logic [ADDR_W-1:0] blk_hi(input logic [ADDR_W-1:0] a, input int w);
        return a | ((ADDR_W'(1) << w) - ADDR_W'(1));
    endfunction
endpackage

// File: rtl/sect_map.sv
module sect_map
    import sect_guard_pkg::*;
#(
    parameter int N_SEC = NSEC,
    parameter int AW    = ADDR_W
) (
    input  logic [AW-1:0]    lo,
    input  logic [AW-1:0]    hi,
    output logic [N_SEC-1:0] hit
);
    // A sector is hit when its span overlaps [lo, hi].
    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        localparam logic [AW-1:0] S_LO = AW'(sec_base(g));
        localparam logic [AW-1:0] S_HI = AW'(sec_last(g));
        assign hit[g] = (S_LO <= hi) && (S_HI >= lo);
    end
endmodule

// File: rtl/prot_store.sv
module prot_store
    import sect_guard_pkg::*;
#(
    parameter int N_SEC = NSEC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_lock,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [N_SEC-1:0] sel,
    output logic [N_SEC-1:0] bits
);
    typedef struct packed {
        logic [N_SEC-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid && !wp_lock) begin
            case (cmd_op)
                PC_SET_ONE: st_d.bits = st_q.bits | sel;
                PC_CLR_ONE: st_d.bits = st_q.bits & ~sel;
                PC_SET_ALL: st_d.bits = '1;
                default:    st_d.bits = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    assign bits = st_q.bits;

    p_wp_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wp_lock |=> $stable(bits));

    p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_lock && cmd_op == PC_CLR_ALL) |=> (bits == '0));

    p_set_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_lock && cmd_op == PC_SET_ALL) |=> (bits == '1));
endmodule

// File: rtl/sect_guard.sv
module sect_guard
    import sect_guard_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int N_SEC  = NSEC,
    parameter int PAGE_W = 8,
    parameter int B4K_W  = 12,
    parameter int B32K_W = 15,
    parameter int B64K_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_lock,
    input  logic             pcmd_valid,
    input  logic [1:0]       pcmd_op,
    input  logic [AW-1:0]    pcmd_addr,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    output logic             grant,
    output logic             reject,
    output logic             err_flag,
    output logic [N_SEC-1:0] prot_bits
);
    typedef struct packed {
        logic grant;
        logic reject;
        logic err;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0]    r_lo, r_hi;
    logic [N_SEC-1:0] req_hit, cmd_sel;
    logic             kind_ok, blocked;

    // Address span touched by the request.
    always_comb begin
        kind_ok = 1'b1;
        case (req_kind)
            RK_PROG: begin r_lo = blk_lo(req_addr, PAGE_W); r_hi = blk_hi(req_addr, PAGE_W); end
            RK_E4K:  begin r_lo = blk_lo(req_addr, B4K_W);  r_hi = blk_hi(req_addr, B4K_W);  end
            RK_E32K: begin r_lo = blk_lo(req_addr, B32K_W); r_hi = blk_hi(req_addr, B32K_W); end
            RK_E64K: begin r_lo = blk_lo(req_addr, B64K_W); r_hi = blk_hi(req_addr, B64K_W); end
            RK_CHIP: begin r_lo = '0; r_hi = '1; end
            default: begin r_lo = '0; r_hi = '1; kind_ok = 1'b0; end
        endcase
    end

    sect_map #(.N_SEC(N_SEC), .AW(AW)) i_req_map (
        .lo (r_lo),
        .hi (r_hi),
        .hit(req_hit)
    );

    sect_map #(.N_SEC(N_SEC), .AW(AW)) i_cmd_map (
        .lo (pcmd_addr),
        .hi (pcmd_addr),
        .hit(cmd_sel)
    );

    prot_store #(.N_SEC(N_SEC)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wp_lock  (wp_lock),
        .cmd_valid(pcmd_valid),
        .cmd_op   (pcmd_op),
        .sel      (cmd_sel),
        .bits     (prot_bits)
    );

    // prot_bits is the pre-command state, so same-cycle commands do not affect the verdict.
    assign blocked = !kind_ok || (|(req_hit & prot_bits));

    always_comb begin
        st_d        = st_q;
        st_d.grant  = req_valid && !blocked;
        st_d.reject = req_valid && blocked;
        if (req_valid) st_d.err = blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant    = st_q.grant;
    assign reject   = st_q.reject;
    assign err_flag = st_q.err;

    p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant ^ reject));

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || reject));

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(err_flag));

    p_chip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == RK_CHIP && (|prot_bits)) |=> reject);

    p_bad_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind > RK_CHIP) |=> reject);

    p_cmd_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pcmd_valid |-> $onehot(cmd_sel));
endmodule

// File: tb/test_sect_guard.sv
module test_sect_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_lock = 1'b0;
    logic        pcmd_valid = 1'b0;
    logic [1:0]  pcmd_op = 2'd0;
    logic [18:0] pcmd_addr = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [18:0] req_addr = '0;
    logic        grant, reject, err_flag;
    logic [10:0] prot_bits;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [10:0] m_prot  = 11'h7FF;
    logic        m_grant = 1'b0;
    logic        m_rej   = 1'b0;
    logic        m_err   = 1'b0;

    always #5 clk = ~clk;

    sect_guard i_sect_guard (
        .clk(clk), .rst_n(rst_n), .wp_lock(wp_lock),
        .pcmd_valid(pcmd_valid), .pcmd_op(pcmd_op), .pcmd_addr(pcmd_addr),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .grant(grant), .reject(reject), .err_flag(err_flag), .prot_bits(prot_bits)
    );

    function automatic int sec_of(input int a);
        if (a < 'h70000) return a / 'h10000;
        if (a < 'h78000) return 7;
        if (a < 'h7A000) return 8;
        if (a < 'h7C000) return 9;
        return 10;
    endfunction

    function automatic bit refused(input int kind, input int a, input logic [10:0] p);
        int sz;
        int lo;
        case (kind)
            0: sz = 'h100;
            1: sz = 'h1000;
            2: sz = 'h8000;
            3: sz = 'h10000;
            4: sz = 'h80000;
            default: return 1'b1;
        endcase
        lo = (a / sz) * sz;
        for (int s = sec_of(lo); s <= sec_of(lo + sz - 1); s++)
            if (p[s]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prot = 11'h7FF; m_grant = 0; m_rej = 0; m_err = 0;
        end else begin
            bit r;
            r = refused(int'(req_kind), int'(req_addr), m_prot);
            m_grant = req_valid && !r;
            m_rej   = req_valid && r;
            if (req_valid) m_err = r;
            if (pcmd_valid && !wp_lock) begin
                case (pcmd_op)
                    2'd0: m_prot[sec_of(int'(pcmd_addr))] = 1'b1;
                    2'd1: m_prot[sec_of(int'(pcmd_addr))] = 1'b0;
                    2'd2: m_prot = 11'h7FF;
                    default: m_prot = 11'h000;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_tests++;
            if (prot_bits !== m_prot || grant !== m_grant || reject !== m_rej || err_flag !== m_err) begin
                n_fail++;
                $display("FAIL %s: prot=%h grant=%b reject=%b err=%b, expected prot=%h grant=%b reject=%b err=%b",
                         cur_req, prot_bits, grant, reject, err_flag, m_prot, m_grant, m_rej, m_err);
            end
        end
    end

    task automatic step(input bit pv, input logic [1:0] op, input int pa,
                        input bit rv, input logic [2:0] rk, input int ra);
        @(negedge clk);
        pcmd_valid = pv; pcmd_op = op; pcmd_addr = 19'(pa);
        req_valid = rv; req_kind = rk; req_addr = 19'(ra);
    endtask

    task automatic pcmd(input logic [1:0] op, input int pa);
        step(1, op, pa, 0, 3'd0, 0);
    endtask

    task automatic req(input logic [2:0] rk, input int ra);
        step(0, 2'd0, 0, 1, rk, ra);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 0, 0, 3'd0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R5"; req(3'd0, 'h12345);
        cur_req = "R9"; idle(3);
        cur_req = "R3"; pcmd(2'd3, 0); idle(1);
        cur_req = "R5"; req(3'd0, 'h12345); idle(1);

        cur_req = "R2"; pcmd(2'd0, 'h7A100); idle(1);
        cur_req = "R6"; req(3'd3, 'h7F000); req(3'd2, 'h70010); req(3'd2, 'h7C123);
        req(3'd1, 'h7B000); req(3'd1, 'h79000); req(3'd3, 'h60000);
        cur_req = "R5"; req(3'd0, 'h7BFFF); req(3'd0, 'h79FFF); req(3'd0, 'h7A0FF);
        cur_req = "R7"; req(3'd4, 0); idle(1);

        cur_req = "R4"; wp_lock = 1'b1;
        pcmd(2'd1, 'h7A000); pcmd(2'd3, 0); pcmd(2'd0, 'h00010); idle(1);
        req(3'd0, 'h7A000);
        wp_lock = 1'b0;
        cur_req = "R2"; pcmd(2'd1, 'h7A000); idle(1);

        cur_req = "R10"; step(1, 2'd0, 'h00100, 1, 3'd0, 'h00100);
        req(3'd0, 'h00100); idle(1);
        step(1, 2'd3, 0, 1, 3'd4, 0);
        req(3'd4, 0); idle(1);

        cur_req = "R11"; req(3'd5, 0); req(3'd6, 'h1000); req(3'd7, 'h7FFFF);
        cur_req = "R9"; idle(2); req(3'd0, 0); idle(2);

        cur_req = "R2";
        for (int s = 0; s < 11; s++) begin
            int base;
            base = (s < 7) ? s * 'h10000 : (s == 7) ? 'h70000 : (s == 8) ? 'h78000 :
                   (s == 9) ? 'h7A000 : 'h7C000;
            pcmd(2'd0, base + 'h40);
            req(3'd0, base + 'h80);
            req(3'd1, base);
            pcmd(2'd1, base + 'h20);
            req(3'd0, base + 'h80);
        end
        cur_req = "R3"; pcmd(2'd2, 0); idle(1);
        cur_req = "R7"; req(3'd4, 'h1234); idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule